// File: doc/BRIEF.md
# Dual-Timeout Watchdog Timer Core

This block is a watchdog timer built around a down-counter. It stays idle after reset until software enables it, after which it counts clock cycles down from a period taken from a fixed table of power-of-two lengths. Each period is selected by a 4-bit code. Two such codes are held at once. One applies from enable until software first restarts the timer, and the other applies from that first restart onward. A restart ("kick") only counts when the written byte equals a fixed key.

When the counter runs out, the block acts in one of two ways. In direct mode it requests a system reset at once. In interrupt-first mode it raises an interrupt, reloads, and requests the reset only if the interrupt is still pending at the following expiry. The reset request is a pulse of fixed length. A pause input stops the count while a debugger holds the processor, and no expiry can happen while it is high. The control port is a set of write strobes with data, intended to sit behind a register-bus wrapper.

Top module: `wdt_core`

## Requirements
- R1: After reset the watchdog is disabled, `irq` and `rst_req` are 0, both period codes are 15 and the response mode is direct (0). While disabled, no output ever asserts.
- R2: An enable write (`en_wr` with `en_val`=1) starts the count by loading the period of the initial code. Code n gives a period of 2^(MIN_EXP+n) cycles, and expiry takes effect exactly one period after any load.
- R3: Loads use the initial code until the first accepted kick. The first kick itself, and every load after it, uses the normal code.
- R4: A kick is accepted only when `kick_wr` is high, `kick_data` equals 0x76 and the watchdog is enabled. An accepted kick reloads the counter. Any other byte, or any kick while disabled, has no effect.
- R5: Once enabled, the watchdog stays enabled until reset. An enable write with `en_val`=0 has no effect, and neither does a repeated enable.
- R6: While `pause` is high the counter holds its value, and neither `irq` nor `rst_req` can newly assert.
- R7: In direct mode (`mode_val`=0), each expiry reloads the counter and drives `rst_req` high for exactly PULSE_CYC (2) cycles. `irq` is not used in this mode.
- R8: In interrupt-first mode (`mode_val`=1), an expiry with `irq` low sets `irq` and reloads the counter. An expiry with `irq` still high issues the reset pulse. Both `irq_clr` and an accepted kick clear `irq`.
- R9: A code written with `cfg_wr` does not change the count in progress. It takes effect at the next load, whether that load is a kick or an expiry.
- R10: With the codes left at their reset value of 15, the first expiry comes 2^(MIN_EXP+15) cycles after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable write data (1 enables; 0 is ignored) |
| cfg_wr | input | 1 | Period code write strobe |
| cfg_init_sel | input | SEL_W | Period code used before the first kick |
| cfg_norm_sel | input | SEL_W | Period code used from the first kick on |
| mode_wr | input | 1 | Response mode write strobe |
| mode_val | input | 1 | 0 = direct reset, 1 = interrupt first |
| kick_wr | input | 1 | Restart write strobe |
| kick_data | input | KEY_W | Restart write data, must equal the key |
| irq_clr | input | 1 | Clears a pending interrupt |
| pause | input | 1 | Freezes counting while high |
| irq | output | 1 | Interrupt from first expiry in interrupt-first mode |
| rst_req | output | 1 | Fixed-length reset request pulse |

## Verification
The bench is built with short periods (MIN_EXP=2). The reference model follows every cycle while the timer runs free on the initial code, and this separates the two codes because their periods differ. Kicks are tried while disabled, with a wrong key, and with a code rewritten in mid-count. These show whether a reload happens and which code it reads. A pause window in mid-count measures whether the count froze or restarted. Interrupt-first runs are tried with the interrupt cleared and with it left pending, which separates the reset path from the interrupt path. One run at the default code confirms the longest table entry and the pulse width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    RESP_RESET     = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_period_dec.sv
module wdt_period_dec #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MIN_EXP = 16
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] load_val
);
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] tbl [NSEL];

  // one table entry per code: period minus one (count reaches zero, then expires)
  for (genvar i = 0; i < NSEL; i++) begin : g_tbl
    localparam int unsigned EXP = MIN_EXP + i;
    assign tbl[i] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  assign load_val = tbl[sel];
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | active;
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  resp_mode_e mode,
  input  logic       irq_clear,
  output logic       irq,
  output logic       rst_req
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic          irq_q, irq_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          fire;

  always_comb begin
    fire   = expire & ((mode == RESP_RESET) | irq_q);
    irq_d  = irq_q;
    if (irq_clear) irq_d = 1'b0;
    if (expire && (mode == RESP_IRQ_FIRST) && !irq_q) irq_d = 1'b1;
    if (fire)                pcnt_d = PW'(PULSE_CYC);
    else if (pcnt_q != '0)   pcnt_d = pcnt_q - PW'(1);
    else                     pcnt_d = pcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      irq_q  <= irq_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign irq     = irq_q;
  assign rst_req = (pcnt_q != '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned         CNT_W     = 32,
  parameter int unsigned         SEL_W     = 4,
  parameter int unsigned         MIN_EXP   = 16,
  parameter int unsigned         KEY_W     = 8,
  parameter logic [KEY_W-1:0]    KICK_KEY  = 8'h76,
  parameter int unsigned         PULSE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_init_sel,
  input  logic [SEL_W-1:0] cfg_norm_sel,
  input  logic             mode_wr,
  input  logic             mode_val,
  input  logic             kick_wr,
  input  logic [KEY_W-1:0] kick_data,
  input  logic             irq_clr,
  input  logic             pause,
  output logic             irq,
  output logic             rst_req
);
  localparam logic [SEL_W-1:0] SEL_RST = '1;

  logic             srst_n;
  logic             en_q, en_d;
  logic             kicked_q, kicked_d;
  logic [SEL_W-1:0] init_sel_q, init_sel_d;
  logic [SEL_W-1:0] norm_sel_q, norm_sel_d;
  resp_mode_e       mode_q, mode_d;

  logic             kick_ok, start, active, cnt_zero, exp_ev, load;
  logic [SEL_W-1:0] sel_use;
  logic [CNT_W-1:0] load_val, cnt_q;

  wdt_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    kick_ok  = kick_wr & (kick_data == KICK_KEY) & en_q;
    start    = en_wr & en_val & ~en_q;
    active   = en_q & ~pause;
    cnt_zero = (cnt_q == '0);
    exp_ev   = active & cnt_zero & ~kick_ok;
    load     = start | kick_ok | exp_ev;
    sel_use  = (kick_ok | kicked_q) ? norm_sel_q : init_sel_q;

    en_d       = en_q | start;
    kicked_d   = kicked_q | kick_ok;
    init_sel_d = cfg_wr  ? cfg_init_sel : init_sel_q;
    norm_sel_d = cfg_wr  ? cfg_norm_sel : norm_sel_q;
    mode_d     = mode_wr ? resp_mode_e'(mode_val) : mode_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q       <= 1'b0;
      kicked_q   <= 1'b0;
      init_sel_q <= SEL_RST;
      norm_sel_q <= SEL_RST;
      mode_q     <= RESP_RESET;
    end else begin
      en_q       <= en_d;
      kicked_q   <= kicked_d;
      init_sel_q <= init_sel_d;
      norm_sel_q <= norm_sel_d;
      mode_q     <= mode_d;
    end
  end

  wdt_period_dec #(
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W),
    .MIN_EXP (MIN_EXP)
  ) u_dec (
    .sel      (sel_use),
    .load_val (load_val)
  );

  wdt_downcnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .active   (active),
    .load     (load),
    .load_val (load_val),
    .cnt_q    (cnt_q)
  );

  wdt_resp #(
    .PULSE_CYC (PULSE_CYC)
  ) u_resp (
    .clk       (clk),
    .rst_n     (srst_n),
    .expire    (exp_ev),
    .mode      (mode_q),
    .irq_clear (kick_ok | irq_clr),
    .irq       (irq),
    .rst_req   (rst_req)
  );
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             pause,
  input logic             kick_ok,
  input logic             mode_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq,
  input logic             rst_req
);
  localparam int unsigned RW = $clog2(PULSE_CYC + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (rst_req) run_q <= run_q + RW'(1);
    else              run_q <= '0;
  end

  assert_pulse_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (run_q < RW'(PULSE_CYC)));

  assert_pulse_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run_q == RW'(PULSE_CYC)));

  assert_direct_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_irq && !irq) |=> !irq);

  assert_sticky_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rst_req && !irq) |=> (!rst_req && !irq));

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pause && !kick_ok) |=> (cnt_q == $past(cnt_q)));

  assert_pause_no_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !rst_req && !irq) |=> (!rst_req && !irq));

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> !irq);
endmodule

bind wdt_core wdt_core_chk #(
  .CNT_W     (CNT_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .en_q     (en_q),
  .pause    (pause),
  .kick_ok  (kick_ok),
  .mode_irq (mode_q),
  .cnt_q    (cnt_q),
  .irq      (irq),
  .rst_req  (rst_req)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  localparam int unsigned CNT_W   = 18;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned MIN_EXP = 2;
  localparam int unsigned KEY_W   = 8;

  logic clk, rst_n;
  logic en_wr, en_val, cfg_wr, mode_wr, mode_val, kick_wr, irq_clr, pause;
  logic [SEL_W-1:0] cfg_init_sel, cfg_norm_sel;
  logic [KEY_W-1:0] kick_data;
  logic irq, rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  bit     m_en, m_kicked, m_mode, m_irq;
  int     m_init, m_norm, m_pulse;
  longint m_cnt;

  wdt_core #(
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W),
    .MIN_EXP (MIN_EXP),
    .KEY_W   (KEY_W)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_wr        (en_wr),
    .en_val       (en_val),
    .cfg_wr       (cfg_wr),
    .cfg_init_sel (cfg_init_sel),
    .cfg_norm_sel (cfg_norm_sel),
    .mode_wr      (mode_wr),
    .mode_val     (mode_val),
    .kick_wr      (kick_wr),
    .kick_data    (kick_data),
    .irq_clr      (irq_clr),
    .pause        (pause),
    .irq          (irq),
    .rst_req      (rst_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    report();
  end

  task automatic model_step();
    bit kick, start, run, expire, fire, n_irq;
    int sel;
    longint reload;
    if (!rst_n) begin
      m_en = 0; m_kicked = 0; m_mode = 0; m_irq = 0;
      m_init = 15; m_norm = 15; m_pulse = 0; m_cnt = 0;
      return;
    end
    kick   = kick_wr && (kick_data == 8'h76) && m_en;
    start  = en_wr && en_val && !m_en;
    run    = m_en && !pause;
    expire = run && (m_cnt == 0) && !kick;
    sel    = (kick || m_kicked) ? m_norm : m_init;
    reload = (longint'(1) << (MIN_EXP + sel)) - 1;
    fire   = expire && (!m_mode || m_irq);
    n_irq  = m_irq;
    if (kick || irq_clr) n_irq = 0;
    if (expire && m_mode && !m_irq) n_irq = 1;
    if (start || kick || expire) m_cnt = reload;
    else if (run) m_cnt = m_cnt - 1;
    if (fire) m_pulse = 2;
    else if (m_pulse > 0) m_pulse = m_pulse - 1;
    m_irq = n_irq;
    m_kicked = m_kicked || kick;
    m_en = m_en || start;
    if (cfg_wr) begin m_init = int'(cfg_init_sel); m_norm = int'(cfg_norm_sel); end
    if (mode_wr) m_mode = mode_val;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (irq !== m_irq || rst_req !== (m_pulse > 0)) begin
      failures++;
      $display("FAIL %s model: irq=%b rst_req=%b (actual) irq=%b rst_req=%b (expected)",
               phase, irq, rst_req, m_irq, (m_pulse > 0));
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    en_wr = 0; en_val = 0; cfg_wr = 0; mode_wr = 0; mode_val = 0;
    kick_wr = 0; kick_data = '0; irq_clr = 0; pause = 0;
    cfg_init_sel = '0; cfg_norm_sel = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic enable();
    en_wr = 1; en_val = 1; tick(); idle();
  endtask

  task automatic set_cfg(input int init_s, input int norm_s);
    cfg_wr = 1; cfg_init_sel = SEL_W'(init_s); cfg_norm_sel = SEL_W'(norm_s);
    tick(); idle();
  endtask

  task automatic kick(input logic [7:0] val);
    kick_wr = 1; kick_data = val; tick(); idle();
  endtask

  // ticks until rst_req is seen high (limit guards a missing pulse)
  task automatic ticks_to_rst(output int n);
    n = 0;
    do begin tick(); n++; end while (rst_req == 0 && n < 300);
  endtask

  task automatic ticks_to_irq(output int n);
    n = 0;
    do begin tick(); n++; end while (irq == 0 && n < 300);
  endtask

  initial begin
    int n;
    idle();
    rst_n = 0;
    #1;
    // R1: reset state and disabled idle
    phase = "R1";
    do_reset();
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "rst_req after reset", int'(rst_req), 0);
    repeat (30) tick();
    check("R1", "rst_req while disabled", int'(rst_req), 0);

    // R4: kick while disabled ignored, so initial code still applies
    phase = "R4";
    set_cfg(1, 3);
    kick(8'h76);
    enable();
    ticks_to_rst(n);
    check("R4", "kick while disabled: cycles to expiry (init code)", n, 8);

    // R10 / R7: default code 15 and pulse width
    phase = "R10";
    do_reset();
    enable();
    repeat (131071) tick();
    check("R10", "rst_req before default period", int'(rst_req), 0);
    tick();
    check("R10", "rst_req at default period", int'(rst_req), 1);
    phase = "R7";
    tick();
    check("R7", "rst_req second pulse cycle", int'(rst_req), 1);
    tick();
    check("R7", "rst_req after two cycles", int'(rst_req), 0);

    // R2 / R3: free run on the initial code, then normal after first kick
    phase = "R3";
    do_reset();
    set_cfg(1, 3);
    enable();
    repeat (10) tick();
    ticks_to_rst(n);
    check("R2", "free-run second expiry interval on init code", n, 6);
    tick(); tick();
    kick(8'h76);
    ticks_to_rst(n);
    check("R3", "cycles to expiry after first kick (normal code)", n, 32);
    tick(); tick();
    ticks_to_rst(n);
    check("R3", "later expiry keeps normal code", n, 30);

    // R4: wrong key ignored
    phase = "R4";
    do_reset();
    set_cfg(1, 1);
    enable();
    repeat (3) tick();
    kick(8'h75);
    ticks_to_rst(n);
    check("R4", "wrong key does not reload", n, 4);

    // R5: disable write and repeated enable ignored
    phase = "R5";
    do_reset();
    set_cfg(1, 1);
    enable();
    en_wr = 1; en_val = 0; tick(); idle();
    en_wr = 1; en_val = 1; tick(); idle();
    ticks_to_rst(n);
    check("R5", "disable/re-enable writes ignored", n, 6);

    // R6: pause freezes count
    phase = "R6";
    do_reset();
    set_cfg(1, 1);
    enable();
    tick(); tick();
    pause = 1;
    repeat (40) tick();
    check("R6", "rst_req during pause", int'(rst_req), 0);
    pause = 0;
    ticks_to_rst(n);
    check("R6", "remaining cycles after pause", n, 6);

    // R8: interrupt-first mode
    phase = "R8";
    do_reset();
    mode_wr = 1; mode_val = 1; cfg_wr = 1; cfg_init_sel = 4'd1; cfg_norm_sel = 4'd1;
    tick(); idle();
    enable();
    ticks_to_irq(n);
    check("R8", "first expiry raises irq", n, 8);
    check("R8", "no reset on first expiry", int'(rst_req), 0);
    irq_clr = 1; tick(); idle();
    check("R8", "irq_clr clears irq", int'(irq), 0);
    ticks_to_irq(n);
    check("R8", "irq again after cleared expiry", n, 7);
    ticks_to_rst(n);
    check("R8", "pending irq -> reset pulse", n, 8);
    check("R8", "irq stays set with pulse", int'(irq), 1);
    tick(); tick();
    kick(8'h76);
    check("R8", "kick clears irq", int'(irq), 0);

    // R9: code write takes effect at next reload
    phase = "R9";
    do_reset();
    set_cfg(1, 1);
    enable();
    kick(8'h76);
    tick();
    set_cfg(1, 3);
    ticks_to_rst(n);
    check("R9", "in-flight count keeps old code", n, 6);
    tick(); tick();
    ticks_to_rst(n);
    check("R9", "new code used after reload", n, 30);

    repeat (5) tick();
    report();
  end
endmodule